// File: doc/BRIEF.md
# Output-Side Handshake Control Unit

This block handles the control lines and the interrupt request for the output-side port of a parallel interface adapter. It watches two peripheral control lines. D1 is always an input. D2 is either an input or an output. Each line has an edge-sensitive flag, and the block drives one active-low interrupt request from those flags. When D2 is an output, it serves as a write strobe toward the peripheral. In handshake mode, a processor write to the data port drives D2 low and the peripheral's D1 edge drives it high again. In pulse mode, D2 drops low for one clock after the write. In the two manual modes, D2 is held at a level chosen by the control register.

The processor side has four signals: a control-register write, a control-register readout, a data-port write strobe and a data-port read strobe. The data-port read clears both flags. Both pins pass through a synchronizer before edge detection, so a pin change shows up in the flags a fixed number of clocks later.

Top module: `hs_ctrl`

## Requirements
- R1: After reset, the control byte reads 0x00, irq_no is high and d2_oe_o is low.
- R2: A D1 pin change is seen by a synchronizer and a previous-sample compare, so flag 7 (readout bit 7) is set at the third rising clock after the pin change.
- R3: Control bit 1 selects the active D1 edge (0 falling, 1 rising). An active D1 edge sets flag 7 whatever the value of bit 0. irq_no is low from flag 7 only when bit 0 is 1.
- R4: With control bit 5 at 0, D2 is an input. Bit 4 selects its active edge (0 falling, 1 rising). An active edge sets flag 6 (readout bit 6), and bit 3 enables irq_no from flag 6.
- R5: A data-port read clears flags 7 and 6 at the next clock. An edge that sets a flag in the same cycle as the read wins, and the flag stays 1.
- R6: In handshake mode (bits 5:3 = 100), d2_o goes low the clock after a data-port write. It goes high again the clock after an active D1 edge.
- R7: In pulse mode (bits 5:3 = 101), d2_o is low for exactly the one clock after each data-port write, and high otherwise.
- R8: Bits 5:3 = 110 hold d2_o low. Bits 5:3 = 111 hold d2_o high.
- R9: d2_oe_o equals control bit 5. Every control-register write sets the handshake/pulse output state high, so d2_o is high after entering an output mode until that mode's first event.
- R10: In handshake mode, a data-port write in the same cycle as an active D1 edge leaves d2_o low.
- R11: While D2 is an output, D2 pin edges never set flag 6.
- R12: Control writes load bits 5:0 only. Readout bits 5:0 return them, and the flags are not changed by a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Control bits 5:0 to load |
| ctl_rdata_o | output | 8 | {flag7, flag6, control bits 5:0} |
| data_wr_i | input | 1 | Processor data-port write strobe |
| data_rd_i | input | 1 | Processor data-port read strobe |
| d1_i | input | 1 | Peripheral control line D1 |
| d2_i | input | 1 | Peripheral control line D2, input side |
| d2_o | output | 1 | D2 output level |
| d2_oe_o | output | 1 | D2 output enable |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Two pairs of events can land in the same cycle. The first pair is an active D1 edge and a flag-clearing data-port read. The second pair, in handshake mode, is a D1 edge and a data-port write that both act on d2_o. To provoke both pairs, the bench toggles D1 every clock while it issues reads. It also sweeps the offset between a write and a D1 change across the synchronizer latency. A behavioural reference model, built on queues of past pin samples, predicts every output each clock and confirms the set-wins rule and the ends-low rule.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned CFG_W = 6;
  localparam logic [2:0] MODE_HS     = 3'b100;
  localparam logic [2:0] MODE_PULSE  = 3'b101;
  localparam logic [2:0] MODE_MAN_LO = 3'b110;
  localparam logic [2:0] MODE_MAN_HI = 3'b111;

  function automatic logic is_manual(input logic [2:0] mode);
    return mode[2] & mode[1];
  endfunction
endpackage

// File: rtl/hs_edge_det.sv
module hs_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign hit_o = rise_sel_i ? (sync_q[STAGES-1] & ~prev_q)
                            : (~sync_q[STAGES-1] & prev_q);
endmodule

// File: rtl/hs_flags.sv
module hs_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d1_hit_i,
  input  logic d2_hit_i,
  input  logic d2_in_i,
  input  logic clr_i,
  output logic f7_o,
  output logic f6_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f7_o <= 1'b0;
      f6_o <= 1'b0;
    end else begin
      // set beats clear
      if (d1_hit_i)             f7_o <= 1'b1;
      else if (clr_i)           f7_o <= 1'b0;
      if (d2_hit_i && d2_in_i)  f6_o <= 1'b1;
      else if (clr_i)           f6_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_d2_out.sv
module hs_d2_out
  import hs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [2:0] mode_i,
  input  logic       wr_i,
  input  logic       d1_hit_i,
  output logic       d2_o,
  output logic       d2_oe_o
);
  logic d2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d2_q <= 1'b1;
    end else if (cfg_we_i) begin
      d2_q <= 1'b1;
    end else begin
      unique case (mode_i)
        MODE_HS: begin
          // write beats a simultaneous D1 edge
          if (wr_i)          d2_q <= 1'b0;
          else if (d1_hit_i) d2_q <= 1'b1;
        end
        MODE_PULSE: d2_q <= ~wr_i;
        default:    d2_q <= d2_q;
      endcase
    end
  end

  assign d2_oe_o = mode_i[2];
  assign d2_o    = !mode_i[2]         ? 1'b1 :
                   is_manual(mode_i)  ? mode_i[0] : d2_q;
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CFG_W-1:0] ctl_wdata_i,
  output logic [7:0]       ctl_rdata_o,
  input  logic             data_wr_i,
  input  logic             data_rd_i,
  input  logic             d1_i,
  input  logic             d2_i,
  output logic             d2_o,
  output logic             d2_oe_o,
  output logic             irq_no
);
  logic [CFG_W-1:0] cfg_q;
  logic d1_hit, d2_hit, f7, f6;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (ctl_we_i) cfg_q <= ctl_wdata_i;
  end

  hs_edge_det #(.STAGES(SYNC_STAGES)) u_d1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(d1_i),
    .rise_sel_i(cfg_q[1]), .hit_o(d1_hit)
  );

  hs_edge_det #(.STAGES(SYNC_STAGES)) u_d2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(d2_i),
    .rise_sel_i(cfg_q[4]), .hit_o(d2_hit)
  );

  hs_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .d1_hit_i(d1_hit), .d2_hit_i(d2_hit),
    .d2_in_i(~cfg_q[5]), .clr_i(data_rd_i), .f7_o(f7), .f6_o(f6)
  );

  hs_d2_out u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(ctl_we_i),
    .mode_i(cfg_q[5:3]), .wr_i(data_wr_i), .d1_hit_i(d1_hit),
    .d2_o(d2_o), .d2_oe_o(d2_oe_o)
  );

  assign ctl_rdata_o = {f7, f6, cfg_q};
  assign irq_no      = ~((f7 & cfg_q[0]) | (f6 & cfg_q[3] & ~cfg_q[5]));
endmodule

// File: rtl/hs_ctrl_chk.sv
module hs_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_we_i,
  input logic [5:0] ctl_wdata_i,
  input logic [7:0] ctl_rdata_o,
  input logic       data_wr_i,
  input logic       data_rd_i,
  input logic       d2_o,
  input logic       d2_oe_o,
  input logic       irq_no,
  input logic       d1_hit,
  input logic       d2_hit
);
  // R3
  d1_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d1_hit |=> ctl_rdata_o[7]);
  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && !d1_hit |=> !ctl_rdata_o[7]);
  // R3
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[7] && !ctl_rdata_o[6] |-> irq_no);
  // R6
  hs_wr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i && data_wr_i && ctl_rdata_o[5:3] == 3'b100 |=> !d2_o);
  // R7
  pulse_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i && data_wr_i && ctl_rdata_o[5:3] == 3'b101 |=> !d2_o);
  // R7
  pulse_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i && !data_wr_i && ctl_rdata_o[5:3] == 3'b101 |=> d2_o);
  // R8
  man_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[5:3] == 3'b110 |-> !d2_o);
  // R8
  man_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[5:3] == 3'b111 |-> d2_o);
  // R9
  enter_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_wdata_i[5:4] == 2'b10 |=> d2_o && d2_oe_o);
  // R11
  f6_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[5] && !ctl_rdata_o[6] |=> !ctl_rdata_o[6]);
  // R4
  d2_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d2_hit && !ctl_rdata_o[5] && !ctl_we_i |=> ctl_rdata_o[6]);
endmodule

bind hs_ctrl hs_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
  .ctl_rdata_o(ctl_rdata_o), .data_wr_i(data_wr_i), .data_rd_i(data_rd_i),
  .d2_o(d2_o), .d2_oe_o(d2_oe_o), .irq_no(irq_no),
  .d1_hit(d1_hit), .d2_hit(d2_hit)
);

// File: tb/hs_ctrl_tb.sv
module hs_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, data_wr = 1'b0, data_rd = 1'b0, d1 = 1'b0, d2 = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic d2_o, d2_oe, irq_n;

  int checks = 0, failures = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata), .data_wr_i(data_wr), .data_rd_i(data_rd),
    .d1_i(d1), .d2_i(d2), .d2_o(d2_o), .d2_oe_o(d2_oe), .irq_no(irq_n)
  );

  // reference model
  int  h1[$], h2[$];
  bit  [5:0] m_cfg;
  bit  m_f7, m_f6, m_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_f7 = 0; m_f6 = 0; m_q = 1;
      h1 = '{0, 0, 0}; h2 = '{0, 0, 0};
    end else begin
      bit e1, e2;
      e1 = m_cfg[1] ? (h1[1] == 1 && h1[2] == 0) : (h1[1] == 0 && h1[2] == 1);
      e2 = m_cfg[4] ? (h2[1] == 1 && h2[2] == 0) : (h2[1] == 0 && h2[2] == 1);
      h1.push_front(int'(d1)); void'(h1.pop_back());
      h2.push_front(int'(d2)); void'(h2.pop_back());
      if (e1) m_f7 = 1; else if (data_rd) m_f7 = 0;
      if (e2 && !m_cfg[5]) m_f6 = 1; else if (data_rd) m_f6 = 0;
      if (ctl_we) m_q = 1;
      else if (m_cfg[5:3] == 3'b100) begin
        if (data_wr) m_q = 0; else if (e1) m_q = 1;
      end else if (m_cfg[5:3] == 3'b101) m_q = !data_wr;
      if (ctl_we) m_cfg = ctl_wdata;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      bit exp_d2, exp_irq;
      exp_d2  = !m_cfg[5] ? 1'b1 : (m_cfg[4] ? m_cfg[3] : m_q);
      exp_irq = !((m_f7 && m_cfg[0]) || (m_f6 && m_cfg[3] && !m_cfg[5]));
      chk("ctl_rdata", int'(ctl_rdata), int'({m_f7, m_f6, m_cfg}));
      chk("d2_o", int'(d2_o), int'(exp_d2));
      chk("d2_oe", int'(d2_oe), int'(m_cfg[5]));
      chk("irq_n", int'(irq_n), int'(exp_irq));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wctl(logic [5:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr;
    @(negedge clk); data_wr = 1; @(negedge clk); data_wr = 0;
  endtask
  task automatic rd;
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tag = "R1";
    cyc(3); rst_n = 1; cyc(3);
    // R2 R3: falling D1, irq masked then enabled
    tag = "R3"; d1 = 1; cyc(5); d1 = 0; cyc(5);
    tag = "R5"; rd(); cyc(2);
    tag = "R3"; wctl(6'h03); d1 = 1; cyc(5); rd(); cyc(2);
    tag = "R2"; d1 = 0; cyc(1); d1 = 1; cyc(5);
    tag = "R12"; wctl(6'h02); cyc(2); rd(); cyc(2);
    // R4: D2 input
    tag = "R4"; wctl(6'h18); d2 = 1; cyc(5); rd(); wctl(6'h08); d2 = 0; cyc(5); rd(); cyc(2);
    // R5: set vs clear race
    tag = "R5"; wctl(6'h01);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); d1 = ~d1; data_rd = (i % 3) != 0;
    end
    @(negedge clk); data_rd = 0; d1 = 0; cyc(5); rd(); cyc(2);
    // R6 R9: handshake
    tag = "R9"; wctl(6'h22); cyc(2);
    tag = "R6"; wr(); cyc(2); d1 = 1; cyc(5); d1 = 0; cyc(3);
    // R10: write vs D1 edge offsets
    tag = "R10";
    for (int off = 0; off < 6; off++) begin
      wctl(6'h22); @(negedge clk); d1 = 1;
      repeat (off) @(negedge clk);
      data_wr = 1; @(negedge clk); data_wr = 0;
      cyc(5); d1 = 0; cyc(4);
    end
    // R11: D2 toggles while output
    tag = "R11"; rd();
    for (int i = 0; i < 8; i++) begin @(negedge clk); d2 = ~d2; end
    cyc(4);
    // R7: pulse
    tag = "R7"; wctl(6'h28); cyc(2); wr(); cyc(2);
    @(negedge clk); data_wr = 1; cyc(3); data_wr = 0; cyc(3);
    // R8: manual
    tag = "R8"; wctl(6'h30); cyc(2); wr(); wctl(6'h38); cyc(2); wr(); cyc(2);
    // R9: re-entry into handshake after low
    tag = "R9"; wctl(6'h20); wr(); cyc(1); wctl(6'h20); cyc(3);
    // mixed random traffic
    tag = "R12";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      ctl_we = ($urandom % 16) == 0; ctl_wdata = 6'($urandom);
      data_wr = ($urandom % 4) == 0; data_rd = ($urandom % 4) == 0;
      d1 = ($urandom % 3) == 0 ? ~d1 : d1;
      d2 = ($urandom % 3) == 0 ? ~d2 : d2;
    end
    @(negedge clk); ctl_we = 0; data_wr = 0; data_rd = 0;
    cyc(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule